// File: doc/BRIEF.md
# Reference Clock Loss Detector

This block watches a reference clock and decides, window by window, whether it is running fast enough to be trusted. A free-running binary counter in the reference domain is Gray coded and carried into a slower timebase domain through a synchronizer chain. At the end of every timebase window the block computes how many reference edges arrived during that window and compares the count with a threshold. The threshold is the threshold frequency times the window length. For a reference whose normal range is 60 to 140 MHz, a loss point of about 10 MHz (and never above 20 MHz) is typical.

A window whose count falls short sends the block to its loss state. In that state the global output-enable drops, which tri-states every clock output pair and the feedback pair together. A PLL power-down request is also raised, which puts the analog loop into its low-power mode. The block comes out of loss only after two consecutive good windows. At that point the power-down request is released, but the outputs stay in high impedance until a lock-settling counter has run out. The block leaves reset in the loss state and waits there until a valid clock has been measured.

Top module: `clk_loss_det`

## Requirements
- R1: From reset assertion until a valid clock has been measured, the outputs are `pll_pd`=1, `clk_valid`=0, `out_en`=0. With the reference stopped they stay this way for any length of time.
- R2: A window whose reference edge count is below `LOSS_THRESH` forces `pll_pd`=1, `clk_valid`=0 and `out_en`=0 one timebase cycle after that window closes, whatever the state was before.
- R3: The power-down request is released only after two consecutive windows at or above `LOSS_THRESH`. A single good window placed between bad windows leaves `pll_pd` at 1.
- R4: When the request is released, `clk_valid` rises and `pll_pd` falls in the same cycle, and `out_en` stays 0.
- R5: If no bad window intervenes, `out_en` rises exactly `LOCK_CYC` timebase cycles after `clk_valid` rises.
- R6: A bad window during the settling period returns the block to loss, and `out_en` does not rise at all.
- R7: Every change of `pll_pd` happens in a cycle that lies a whole number of `WIN_CYC` periods from every other such change. Window decisions have a fixed phase.
- R8: Once the outputs are enabled, changes of reference frequency that stay above the threshold (20 to 140 MHz against a 125 MHz timebase, with `WIN_CYC`=64 and `LOSS_THRESH`=8) leave all three outputs unchanged.
- R9: `out_en`=1 implies `clk_valid`=1, and `clk_valid` is always the inverse of `pll_pd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock being measured |
| tb_clk | input | 1 | Free-running timebase clock that times the windows |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_valid | output | 1 | High while the reference is judged present (settling or running) |
| out_en | output | 1 | Global enable for all clock output pairs and the feedback pair |
| pll_pd | output | 1 | PLL power-down / low-power request |

`CNT_W` must hold more than the largest edge count one window can see.

## Verification
The bench aligns a burst of reference edges to one full window, using the window phase it learns from earlier transitions. A design that released power-down after a single good window would drop `pll_pd` during that burst. It cuts the reference right after `clk_valid` rises and before `LOCK_CYC` has elapsed. A design whose lock counter ignored loss would then raise `out_en` on a dead clock. It measures the exact delay from `clk_valid` to `out_en` to catch off-by-one errors in the lock count, and it runs the reference at 20 MHz and 140 MHz. A comparison that was wrong at the threshold, or a counter that wrapped, would flip the outputs there.

// File: rtl/cld_pkg.sv
package cld_pkg;
  typedef enum logic [1:0] {
    ST_LOSS   = 2'd0,
    ST_QUAL   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } cld_state_e;
endpackage

// File: rtl/cld_rst_sync.sv
module cld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cld_edge_cnt.sv
module cld_edge_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_out
);
  logic [CNT_W-1:0] bin_q, bin_d;
  logic [CNT_W-1:0] gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray_out = gray_q;
endmodule

// File: rtl/cld_gray_sync.sv
module cld_gray_sync #(
  parameter int CNT_W  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_out
);
  logic [CNT_W-1:0] stg_q [STAGES];
  logic [CNT_W-1:0] gray_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign gray_s = stg_q[STAGES-1];

  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_g2b
    assign bin_out[gi] = ^gray_s[CNT_W-1:gi];
  end
endmodule

// File: rtl/cld_window.sv
module cld_window #(
  parameter int WIN_CYC     = 64,
  parameter int LOSS_THRESH = 8,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_bin,
  output logic             win_vld,
  output logic             win_ok
);
  localparam int WC_W = $clog2(WIN_CYC);
  localparam logic [WC_W-1:0]  LAST_IDX = WC_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] THR      = CNT_W'(LOSS_THRESH);

  logic [WC_W-1:0]  wcnt_q, wcnt_d;
  logic [CNT_W-1:0] snap_q, delta;
  logic             last, pass;
  logic             vld_q, ok_q;

  always_comb begin
    last   = (wcnt_q == LAST_IDX);
    wcnt_d = last ? '0 : wcnt_q + 1'b1;
    delta  = cnt_bin - snap_q;
    pass   = (delta >= THR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      snap_q <= '0;
      vld_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      vld_q  <= last;
      if (last) begin
        snap_q <= cnt_bin;
        ok_q   <= pass;
      end
    end
  end

  assign win_vld = vld_q;
  assign win_ok  = ok_q;
endmodule

// File: rtl/cld_ctrl.sv
module cld_ctrl
  import cld_pkg::*;
#(
  parameter int LOCK_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_vld,
  input  logic win_ok,
  output logic clk_valid,
  output logic out_en,
  output logic pll_pd
);
  localparam int LC_W = $clog2(LOCK_CYC + 1);
  localparam logic [LC_W-1:0] LC_LOAD = LC_W'(LOCK_CYC - 1);

  cld_state_e      state_q, state_d;
  logic [LC_W-1:0] lcnt_q, lcnt_d;
  logic            lcnt_en;
  logic            bad_win, good_win;

  always_comb begin
    bad_win  = win_vld & ~win_ok;
    good_win = win_vld &  win_ok;
    state_d  = state_q;
    lcnt_d   = lcnt_q;
    lcnt_en  = 1'b0;
    case (state_q)
      ST_LOSS: begin
        if (good_win) state_d = ST_QUAL;
      end
      ST_QUAL: begin
        if (good_win) begin
          state_d = ST_SETTLE;
          lcnt_en = 1'b1;
          lcnt_d  = LC_LOAD;
        end else if (bad_win) begin
          state_d = ST_LOSS;
        end
      end
      ST_SETTLE: begin
        if (bad_win) begin
          state_d = ST_LOSS;
        end else if (lcnt_q == '0) begin
          state_d = ST_RUN;
        end else begin
          lcnt_en = 1'b1;
          lcnt_d  = lcnt_q - 1'b1;
        end
      end
      ST_RUN: begin
        if (bad_win) state_d = ST_LOSS;
      end
      default: state_d = ST_LOSS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOSS;
      lcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (lcnt_en) lcnt_q <= lcnt_d;
    end
  end

  assign pll_pd    = (state_q == ST_LOSS) || (state_q == ST_QUAL);
  assign clk_valid = (state_q == ST_SETTLE) || (state_q == ST_RUN);
  assign out_en    = (state_q == ST_RUN);
endmodule

// File: rtl/clk_loss_det.sv
module clk_loss_det #(
  parameter int WIN_CYC     = 64,
  parameter int LOSS_THRESH = 8,
  parameter int LOCK_CYC    = 100,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic tb_clk,
  input  logic rst_n,
  output logic clk_valid,
  output logic out_en,
  output logic pll_pd
);
  logic             ref_rst_n;
  logic             tb_rst_n;
  logic [CNT_W-1:0] ref_gray;
  logic [CNT_W-1:0] ref_bin_tb;
  logic             win_vld;
  logic             win_ok;

  cld_rst_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n)
  );

  cld_rst_sync #(.STAGES(SYNC_STAGES)) u_tb_rst (
    .clk(tb_clk), .arst_n(rst_n), .srst_n(tb_rst_n)
  );

  cld_edge_cnt #(.CNT_W(CNT_W)) u_edge_cnt (
    .ref_clk(ref_clk), .rst_n(ref_rst_n), .gray_out(ref_gray)
  );

  cld_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_gray_sync (
    .clk(tb_clk), .rst_n(tb_rst_n), .gray_in(ref_gray), .bin_out(ref_bin_tb)
  );

  cld_window #(.WIN_CYC(WIN_CYC), .LOSS_THRESH(LOSS_THRESH), .CNT_W(CNT_W)) u_window (
    .clk(tb_clk), .rst_n(tb_rst_n), .cnt_bin(ref_bin_tb),
    .win_vld(win_vld), .win_ok(win_ok)
  );

  cld_ctrl #(.LOCK_CYC(LOCK_CYC)) u_ctrl (
    .clk(tb_clk), .rst_n(tb_rst_n), .win_vld(win_vld), .win_ok(win_ok),
    .clk_valid(clk_valid), .out_en(out_en), .pll_pd(pll_pd)
  );
endmodule

// File: rtl/cld_chk.sv
module cld_chk #(
  parameter int LOCK_CYC = 100
) (
  input logic tb_clk,
  input logic rst_n,
  input logic win_vld,
  input logic win_ok,
  input logic clk_valid,
  input logic out_en,
  input logic pll_pd
);
  localparam int CW = $clog2(LOCK_CYC + 2);

  logic [CW-1:0] settle_cnt;

  always_ff @(posedge tb_clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
    end else if (clk_valid && !out_en) begin
      if (settle_cnt != '1) settle_cnt <= settle_cnt + 1'b1;
    end else begin
      settle_cnt <= '0;
    end
  end

  // R1
  always @(posedge tb_clk) begin
    if (!rst_n) begin
      reset_loss_chk: assert (pll_pd && !out_en && !clk_valid)
        else $error("reset state wrong");
    end
  end

  // R2
  loss_window_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
    (win_vld && !win_ok) |=> (pll_pd && !clk_valid && !out_en));

  // R3
  release_on_good_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
    $fell(pll_pd) |-> ($past(win_vld) && $past(win_ok)));

  // R5
  settle_len_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
    $rose(out_en) |-> ($past(clk_valid) && settle_cnt == CW'(LOCK_CYC)));

  // R9
  en_needs_valid_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
    out_en |-> clk_valid);

  // R9
  valid_vs_pd_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
    clk_valid != pll_pd);
endmodule

bind clk_loss_det cld_chk #(.LOCK_CYC(LOCK_CYC)) u_cld_chk (
  .tb_clk(tb_clk), .rst_n(rst_n), .win_vld(win_vld), .win_ok(win_ok),
  .clk_valid(clk_valid), .out_en(out_en), .pll_pd(pll_pd)
);

// File: tb/test_clk_loss_det.sv
`timescale 1ns/1ps
module test_clk_loss_det;
  localparam int WIN  = 64;
  localparam int THR  = 8;
  localparam int LOCK = 100;

  logic tb_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n;
  logic clk_valid, out_en, pll_pd;

  bit  ref_run = 1'b0;
  real ref_half = 5.0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  logic [2:0] last_o;
  bit mon_on = 1'b0;
  int t_vrise = 0;
  int t_pdfall = 0;
  int ph = 0;
  bit have_ph = 1'b0;

  clk_loss_det #(.WIN_CYC(WIN), .LOSS_THRESH(THR), .LOCK_CYC(LOCK), .CNT_W(10), .SYNC_STAGES(2))
    i_clk_loss_det (
      .ref_clk(ref_clk), .tb_clk(tb_clk), .rst_n(rst_n),
      .clk_valid(clk_valid), .out_en(out_en), .pll_pd(pll_pd)
    );

  always #4 tb_clk = ~tb_clk;

  always begin
    if (ref_run) begin
      #(ref_half);
      ref_clk = ~ref_clk;
    end else begin
      ref_clk = 1'b0;
      wait (ref_run);
    end
  end

  always @(posedge tb_clk) cyc <= cyc + 1;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expected outputs are encoded {clk_valid, out_en, pll_pd}
  task automatic push(input logic [2:0] e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic wait_sig(input int sel, input logic val, input int limit, input string req);
    int n = 0;
    bit hit = 1'b0;
    while (!hit && n < limit) begin
      @(negedge tb_clk);
      n++;
      case (sel)
        0:       hit = (clk_valid == val);
        1:       hit = (out_en == val);
        default: hit = (pll_pd == val);
      endcase
    end
    chk(hit, req, int'(hit), 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge tb_clk);
  endtask

  // monitor: pops the scoreboard on every output change
  always @(negedge tb_clk) begin
    logic [2:0] cur, e;
    string t;
    if (mon_on) begin
      cur = {clk_valid, out_en, pll_pd};
      if (cur != last_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected change", int'(cur), int'(last_o));
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cur == e, t, int'(cur), int'(e));
        end
        if (cur[2] && !last_o[2]) t_vrise = cyc;
        if (cur[1] && !last_o[1]) chk((cyc - t_vrise) == LOCK, "R5 settle length", cyc - t_vrise, LOCK);
        if (cur[0] != last_o[0]) begin
          if (!cur[0]) t_pdfall = cyc;
          if (have_ph) chk(((cyc - ph) % WIN) == 0, "R7 window phase", (cyc - ph) % WIN, 0);
          else begin
            have_ph = 1'b1;
            ph = cyc;
          end
        end
        last_o = cur;
      end
    end
  end

  always @(negedge tb_clk) begin
    if (!done && cyc > 150000) begin
      done = 1'b1;
      chk(1'b0, "watchdog", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t0;
    int d;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    idle(5);
    // R1: reset state
    chk({clk_valid, out_en, pll_pd} == 3'b001, "R1 during reset", int'({clk_valid, out_en, pll_pd}), 1);
    rst_n = 1'b1;
    last_o = {clk_valid, out_en, pll_pd};
    mon_on = 1'b1;
    idle(3 * WIN);
    chk({clk_valid, out_en, pll_pd} == 3'b001, "R1 no clock stays lost", int'({clk_valid, out_en, pll_pd}), 1);

    // R4 / R5: first recovery at 100 MHz
    push(3'b100, "R4 release");
    push(3'b110, "R5 enable");
    t0 = cyc;
    ref_half = 5.0;
    ref_run = 1'b1;
    wait_sig(1, 1'b1, 4 * WIN + LOCK, "R5 enable reached");
    idle(1);
    chk((t_pdfall - t0) >= WIN && (t_pdfall - t0) <= 2 * WIN + 8, "R3 two-window release",
        t_pdfall - t0, WIN);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    // R2: drop to 10 MHz from running
    push(3'b001, "R2 loss at 10 MHz");
    t0 = cyc;
    ref_half = 50.0;
    wait_sig(2, 1'b1, 3 * WIN, "R2 loss reached");
    chk((cyc - t0) <= 2 * WIN + 4, "R2 loss latency", cyc - t0, 2 * WIN);

    // R6: recover at 60 MHz, then lose the clock during settling
    push(3'b100, "R4 release at 60 MHz");
    push(3'b001, "R6 abort settle");
    ref_half = 8.333;
    wait_sig(0, 1'b1, 4 * WIN, "R4 valid at 60 MHz");
    ref_run = 1'b0;
    wait_sig(2, 1'b1, 2 * WIN, "R6 back to loss");
    idle(LOCK + 10);
    chk(out_en == 1'b0, "R6 enable never rose", int'(out_en), 0);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

    // R3: exactly one good window, aligned to the learned window phase
    d = cyc + 2;
    while (((d - ph) % WIN) != 0) d++;
    while (cyc < d) @(negedge tb_clk);
    ref_half = 5.0;
    ref_run = 1'b1;
    idle(WIN - 4);
    ref_run = 1'b0;
    idle(4 * WIN);
    chk(pll_pd == 1'b1, "R3 single good window ignored", int'(pll_pd), 1);
    chk(clk_valid == 1'b0, "R3 valid stays low", int'(clk_valid), 0);

    // R8: recover at 20 MHz, then sweep within range
    push(3'b100, "R4 release at 20 MHz");
    push(3'b110, "R5 enable at 20 MHz");
    ref_half = 25.0;
    ref_run = 1'b1;
    wait_sig(1, 1'b1, 4 * WIN + LOCK, "R5 enable at 20 MHz");
    ref_half = 3.571;
    idle(4 * WIN);
    chk({clk_valid, out_en, pll_pd} == 3'b110, "R8 stable at 140 MHz", int'({clk_valid, out_en, pll_pd}), 6);
    ref_half = 8.333;
    idle(4 * WIN);
    chk({clk_valid, out_en, pll_pd} == 3'b110, "R8 stable at 60 MHz", int'({clk_valid, out_en, pll_pd}), 6);

    // R2: stopped clock from running
    push(3'b001, "R2 loss on stop");
    ref_run = 1'b0;
    wait_sig(2, 1'b1, 3 * WIN, "R2 loss on stop reached");
    idle(2);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule